// File: doc/BRIEF.md
# CAN Controller Mode Handshake Sequencer

This block sequences the three mode changes of a CAN controller: soft reset, freeze and module disable. Software drives them through a control register in the host clock domain. A chip-level soft-reset line can also start a soft reset. The protocol engine runs on its own clock and reports whether a transmit or receive is in progress. Every request crosses to the protocol domain through a two-flop synchronizer, and every grant comes back through another.

A soft reset stays visible as bit 0 of the control register until the protocol domain has acknowledged it. The bit then clears itself. On completion the block emits a one-cycle clear strobe for each register that soft reset affects and none for the registers that it preserves. Freeze and disable are granted only on a protocol-domain cycle in which transmit and receive are both idle. While either grant is held, the bit-time prescaler is stopped. A freeze requested while the module is disabled waits until the disabled state has been left. A pending soft reset holds back any mode request until the reset completes.

Top module: `can_mode_seq`

## Requirements
- R1: Control bit 0 (soft reset) is set by a register write with bit 0 at 1 or by `glb_srst_i`. A write with bit 0 at 0 cannot clear it while a reset is pending.
- R2: A soft reset produces exactly one single-cycle `pe_srst_o` pulse in the protocol domain. Bit 0 clears itself only after the protocol-domain acknowledge has come back across the synchronizer.
- R3: On soft-reset completion the control register is cleared except bit 2 (disable), which keeps its value. This includes bit 1 (freeze) and the general bits 7:3.
- R4: On completion `reg_clr_o` pulses for one cycle with bits 6:0 set: timer, error counters, error status, low and high interrupt masks, low and high interrupt flags. Bits 11:7 (bus configuration, global acceptance mask, two per-buffer acceptance masks, message buffers) never pulse.
- R5: Freeze (control bit 1) is granted only on a protocol cycle with `pe_tx_busy_i` and `pe_rx_busy_i` both low. While it is granted `pe_presc_en_o` is low, and `frz_ack_o` follows the grant through a two-flop synchronizer.
- R6: When freeze is withdrawn the prescaler restarts first. `frz_ack_o` falls only after that.
- R7: While disable is requested or granted, a freeze request is not granted. It is granted after disable is cleared and the disabled grant has dropped.
- R8: Disable (control bit 2) is granted only on a protocol cycle with both busy inputs low. `lpm_ack_o` reports the grant, the prescaler is stopped, and clearing bit 2 releases the grant.
- R9: Freeze and disable request changes made while a soft reset is pending do not reach the protocol domain. After completion the request is taken again from the control register as left by the reset.
- R10: After `rst_ni` the control register, both acknowledges, `reg_clr_o` and `pe_srst_o` are 0 and `pe_presc_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | CTRL_W | Control register write data |
| glb_srst_i | input | 1 | Chip-level soft-reset request |
| ctrl_o | output | CTRL_W | Control register readback |
| frz_ack_o | output | 1 | Freeze acknowledge, host domain |
| lpm_ack_o | output | 1 | Disabled acknowledge, host domain |
| reg_clr_o | output | 12 | Per-register soft-reset clear strobes |
| pe_clk_i | input | 1 | Protocol-engine clock |
| pe_tx_busy_i | input | 1 | Transmit in progress |
| pe_rx_busy_i | input | 1 | Receive in progress |
| pe_presc_en_o | output | 1 | Prescaler enable, protocol domain |
| pe_srst_o | output | 1 | Soft-reset pulse to protocol state machines |

## Verification
The bench holds a bus-busy input high across a freeze request and a disable request. A sequencer that ignores bus activity would drop the prescaler too early. It requests freeze while disabled, which exposes a design that grants freeze at once, and it attempts to clear the soft-reset bit by a write while the reset is pending. It also changes the freeze request during a pending reset. A design without reset priority would stop the prescaler there even though the reset then clears the freeze bit. A reference model predicts every output on every cycle. Separate counts confirm one reset pulse and one clear strobe per reset, with the preserved registers never strobed.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int unsigned SRST_BIT = 0;
  localparam int unsigned FRZ_BIT  = 1;
  localparam int unsigned DIS_BIT  = 2;

  typedef enum logic [3:0] {
    RG_TIMER, RG_ERR_CNT, RG_ERR_STAT, RG_IMASK_LO, RG_IMASK_HI,
    RG_IFLAG_LO, RG_IFLAG_HI, RG_BUS_CFG, RG_ACC_G, RG_ACC_A,
    RG_ACC_B, RG_MSG_BUF
  } reg_id_e;
  localparam int unsigned NUM_REGS = 12;

  typedef enum logic [1:0] {SR_IDLE, SR_REQ, SR_DRAIN} srst_st_e;

  function automatic logic srst_clears(reg_id_e id);
    case (id)
      RG_TIMER, RG_ERR_CNT, RG_ERR_STAT, RG_IMASK_LO, RG_IMASK_HI,
      RG_IFLAG_LO, RG_IFLAG_HI: return 1'b1;
      default:                  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srst_host_fsm.sv
module srst_host_fsm
  import can_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o,
  output logic busy_o
);
  srst_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SR_IDLE:  if (start_i) st_d = SR_REQ;
      SR_REQ:   if (ack_i)   st_d = SR_DRAIN;
      SR_DRAIN: if (!ack_i)  st_d = SR_IDLE;
      default:               st_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SR_IDLE;
    else         st_q <= st_d;
  end

  assign req_o  = (st_q == SR_REQ);
  assign done_o = (st_q == SR_REQ) && ack_i;
  assign busy_o = (st_q != SR_IDLE);
endmodule

// File: rtl/srst_pe_ack.sv
module srst_pe_ack (
  input  logic pe_clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  output logic ack_o,
  output logic srst_pulse_o
);
  logic ack_q;

  always_ff @(posedge pe_clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_s_i;
  end

  assign ack_o        = ack_q;
  assign srst_pulse_o = req_s_i & ~ack_q;
endmodule

// File: rtl/mode_grant.sv
module mode_grant (
  input  logic pe_clk_i,
  input  logic rst_ni,
  input  logic frz_req_i,
  input  logic dis_req_i,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  output logic frz_gnt_o,
  output logic lpm_gnt_o,
  output logic presc_en_o
);
  logic frz_q, lpm_q, frz_d, lpm_d, bus_idle;

  assign bus_idle = ~tx_busy_i & ~rx_busy_i;
  // grants only start on an idle cycle; freeze waits out the disabled state
  assign lpm_d = dis_req_i & (lpm_q | bus_idle);
  assign frz_d = frz_req_i & (frz_q | (bus_idle & ~dis_req_i & ~lpm_q));

  always_ff @(posedge pe_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= 1'b0;
      lpm_q <= 1'b0;
    end else begin
      frz_q <= frz_d;
      lpm_q <= lpm_d;
    end
  end

  assign frz_gnt_o  = frz_q;
  assign lpm_gnt_o  = lpm_q;
  assign presc_en_o = ~(frz_q | lpm_q);
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CTRL_W-1:0]   wr_data_i,
  input  logic                glb_srst_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                frz_ack_o,
  output logic                lpm_ack_o,
  output logic [NUM_REGS-1:0] reg_clr_o,
  input  logic                pe_clk_i,
  input  logic                pe_tx_busy_i,
  input  logic                pe_rx_busy_i,
  output logic                pe_presc_en_o,
  output logic                pe_srst_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic srst_req, srst_done, srst_busy, srst_pend;
  logic srst_req_s, srst_ack_pe, srst_ack_s;
  logic fwd_frz_q, fwd_dis_q;
  logic [1:0] mode_req_s;
  logic frz_gnt, lpm_gnt;
  logic [1:0] gnt_s;

  always_comb begin
    ctrl_d = ctrl_q;
    if (srst_done) begin
      ctrl_d           = '0;
      ctrl_d[DIS_BIT]  = ctrl_q[DIS_BIT];
      ctrl_d[SRST_BIT] = glb_srst_i;
    end else begin
      if (wr_en_i) ctrl_d = wr_data_i;
      if (glb_srst_i || ctrl_q[SRST_BIT]) ctrl_d[SRST_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign srst_pend = ctrl_q[SRST_BIT] | srst_busy;

  // mode requests are held while a soft reset is outstanding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_frz_q <= 1'b0;
      fwd_dis_q <= 1'b0;
    end else if (!srst_pend) begin
      fwd_frz_q <= ctrl_q[FRZ_BIT];
      fwd_dis_q <= ctrl_q[DIS_BIT];
    end
  end

  srst_host_fsm u_srst_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ctrl_q[SRST_BIT]),
    .ack_i  (srst_ack_s),
    .req_o  (srst_req),
    .done_o (srst_done),
    .busy_o (srst_busy)
  );

  cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_srst_req (
    .clk_i(pe_clk_i), .rst_ni(rst_ni), .d_i(srst_req), .q_o(srst_req_s)
  );

  srst_pe_ack u_srst_ack (
    .pe_clk_i    (pe_clk_i),
    .rst_ni      (rst_ni),
    .req_s_i     (srst_req_s),
    .ack_o       (srst_ack_pe),
    .srst_pulse_o(pe_srst_o)
  );

  cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_srst_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(srst_ack_pe), .q_o(srst_ack_s)
  );

  cdc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_mode_req (
    .clk_i(pe_clk_i), .rst_ni(rst_ni), .d_i({fwd_dis_q, fwd_frz_q}), .q_o(mode_req_s)
  );

  mode_grant u_grant (
    .pe_clk_i  (pe_clk_i),
    .rst_ni    (rst_ni),
    .frz_req_i (mode_req_s[0]),
    .dis_req_i (mode_req_s[1]),
    .tx_busy_i (pe_tx_busy_i),
    .rx_busy_i (pe_rx_busy_i),
    .frz_gnt_o (frz_gnt),
    .lpm_gnt_o (lpm_gnt),
    .presc_en_o(pe_presc_en_o)
  );

  cdc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_gnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({lpm_gnt, frz_gnt}), .q_o(gnt_s)
  );

  for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_clr
    localparam logic CLR_SEL = srst_clears(reg_id_e'(i));
    assign reg_clr_o[i] = srst_done & CLR_SEL;
  end

  assign ctrl_o    = ctrl_q;
  assign frz_ack_o = gnt_s[0];
  assign lpm_ack_o = gnt_s[1];
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk
  import can_mode_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CTRL_W-1:0]   ctrl_o,
  input logic [NUM_REGS-1:0] reg_clr_o,
  input logic                pe_clk_i,
  input logic                pe_tx_busy_i,
  input logic                pe_rx_busy_i,
  input logic                pe_presc_en_o,
  input logic                pe_srst_o
);
  // R1
  srst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[SRST_BIT] && reg_clr_o == '0) |=> ctrl_o[SRST_BIT]);

  // R3
  srst_frz_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_clr_o != '0) |=> !ctrl_o[FRZ_BIT]);

  // R3
  srst_dis_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_clr_o != '0) |=> (ctrl_o[DIS_BIT] == $past(ctrl_o[DIS_BIT])));

  // R2
  pe_srst_pulse_chk: assert property (@(posedge pe_clk_i) disable iff (!rst_ni)
    pe_srst_o |=> !pe_srst_o);

  // R5
  presc_stop_idle_chk: assert property (@(posedge pe_clk_i) disable iff (!rst_ni)
    $fell(pe_presc_en_o) |-> $past(!pe_tx_busy_i && !pe_rx_busy_i));
endmodule

bind can_mode_seq can_mode_seq_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_o       (ctrl_o),
  .reg_clr_o    (reg_clr_o),
  .pe_clk_i     (pe_clk_i),
  .pe_tx_busy_i (pe_tx_busy_i),
  .pe_rx_busy_i (pe_rx_busy_i),
  .pe_presc_en_o(pe_presc_en_o),
  .pe_srst_o    (pe_srst_o)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  localparam int CW = 8;
  localparam int NR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic glb = 1'b0;
  logic tx = 1'b0, rx = 1'b0;
  logic [CW-1:0] ctrl;
  logic frz_ack, lpm_ack, presc, pe_srst;
  logic [NR-1:0] clr;

  always #2.5 clk = ~clk;

  can_mode_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .glb_srst_i(glb), .ctrl_o(ctrl), .frz_ack_o(frz_ack), .lpm_ack_o(lpm_ack),
    .reg_clr_o(clr), .pe_clk_i(clk), .pe_tx_busy_i(tx), .pe_rx_busy_i(rx),
    .pe_presc_en_o(presc), .pe_srst_o(pe_srst)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int clr_seen = 0, clr_bad = 0, srst_pulses = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model: integer state, delay lines of two stages
  int m_ctrl, m_ffrz, m_fdis, m_st;
  int m_r[2], m_pack, m_k[2], m_f[2], m_d[2], m_frz, m_lpm, m_a[2], m_l[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ffrz = 0; m_fdis = 0; m_st = 0; m_pack = 0;
      m_r = '{0, 0}; m_k = '{0, 0}; m_f = '{0, 0}; m_d = '{0, 0};
      m_frz = 0; m_lpm = 0; m_a = '{0, 0}; m_l = '{0, 0};
    end else begin
      int n_ctrl, n_st, n_frz, n_lpm, pend, idle, done_now;
      idle = !(tx || rx);
      done_now = (m_st == 1) && m_k[1];
      if (done_now) n_ctrl = (m_ctrl & 4) | (glb ? 1 : 0);
      else begin
        n_ctrl = wr_en ? int'(wr_data) : m_ctrl;
        if (glb || (m_ctrl & 1)) n_ctrl |= 1;
      end
      pend = (m_ctrl & 1) || (m_st != 0);
      case (m_st)
        0: n_st = (m_ctrl & 1) ? 1 : 0;
        1: n_st = m_k[1] ? 2 : 1;
        default: n_st = m_k[1] ? 2 : 0;
      endcase
      n_lpm = m_d[1] && (m_lpm || idle);
      n_frz = m_f[1] && (m_frz || (idle && !m_d[1] && !m_lpm));
      m_a[1] = m_a[0]; m_a[0] = m_frz;
      m_l[1] = m_l[0]; m_l[0] = m_lpm;
      m_k[1] = m_k[0]; m_k[0] = m_pack;
      m_pack = m_r[1];
      m_r[1] = m_r[0]; m_r[0] = (m_st == 1);
      m_f[1] = m_f[0]; m_f[0] = m_ffrz;
      m_d[1] = m_d[0]; m_d[0] = m_fdis;
      if (!pend) begin m_ffrz = (m_ctrl >> 1) & 1; m_fdis = (m_ctrl >> 2) & 1; end
      m_frz = n_frz; m_lpm = n_lpm; m_st = n_st; m_ctrl = n_ctrl;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R1/R3 ctrl_o", int'(ctrl), m_ctrl);
      chk("R5/R6 frz_ack_o", int'(frz_ack), m_a[1]);
      chk("R8 lpm_ack_o", int'(lpm_ack), m_l[1]);
      chk("R5/R7/R9 pe_presc_en_o", int'(presc), (m_frz || m_lpm) ? 0 : 1);
      chk("R2 pe_srst_o", int'(pe_srst), (m_r[1] && !m_pack) ? 1 : 0);
      chk("R4 reg_clr_o", int'(clr), ((m_st == 1) && m_k[1]) ? 'h07F : 0);
      if (clr == 12'h07F) clr_seen++;
      if (clr[11:7] != 0) clr_bad++;
      if (pe_srst) srst_pulses++;
    end
  end

  task automatic wr(input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int lfsr;
    idle(3);
    // R10 reset state
    chk("R10 ctrl", int'(ctrl), 0);
    chk("R10 presc", int'(presc), 1);
    chk("R10 acks", int'({frz_ack, lpm_ack}), 0);
    chk("R10 clr", int'(clr), 0);
    @(negedge clk); rst_n = 1'b1;
    wr(8'hF8);
    chk("R3 misc write", int'(ctrl), 'hF8);
    wr(8'h00);

    // R5 freeze held off by transmit activity
    tx = 1'b1;
    wr(8'h02);
    idle(12);
    chk("R5 busy holds presc", int'(presc), 1);
    chk("R5 busy holds ack", int'(frz_ack), 0);
    tx = 1'b0;
    idle(8);
    chk("R5 granted presc", int'(presc), 0);
    chk("R5 granted ack", int'(frz_ack), 1);

    // R6 withdraw: prescaler resumes before ack falls
    wr(8'h00);
    while (!presc) @(negedge clk);
    chk("R6 ack still set on restart", int'(frz_ack), 1);
    idle(6);
    chk("R6 ack cleared", int'(frz_ack), 0);

    // R8 disable held off by receive activity
    rx = 1'b1;
    wr(8'h04);
    idle(10);
    chk("R8 busy holds lpm", int'(lpm_ack), 0);
    rx = 1'b0;
    idle(8);
    chk("R8 lpm granted", int'(lpm_ack), 1);
    chk("R8 presc stopped", int'(presc), 0);

    // R7 freeze while disabled
    wr(8'h06);
    idle(10);
    chk("R7 no freeze while disabled", int'(frz_ack), 0);
    wr(8'h02);
    idle(12);
    chk("R7 lpm left", int'(lpm_ack), 0);
    chk("R7 freeze after exit", int'(frz_ack), 1);
    wr(8'h00);
    idle(8);

    // R1/R2/R3/R4 soft reset by write
    clr_seen = 0; clr_bad = 0; srst_pulses = 0;
    wr(8'hF5);
    chk("R1 srst set", int'(ctrl[0]), 1);
    wr(8'h04);
    chk("R1 write 0 ignored", int'(ctrl[0]), 1);
    idle(20);
    chk("R3 kept only disable", int'(ctrl), 'h04);
    chk("R4 clear strobes", clr_seen, 1);
    chk("R4 preserved regs", clr_bad, 0);
    chk("R2 one pe pulse", srst_pulses, 1);
    chk("R8 lpm still granted", int'(lpm_ack), 1);
    wr(8'h00);
    idle(8);

    // R1/R2 global soft reset
    srst_pulses = 0;
    @(negedge clk); glb = 1'b1;
    @(negedge clk); glb = 1'b0;
    chk("R1 glb sets srst", int'(ctrl[0]), 1);
    idle(20);
    chk("R2 self clears", int'(ctrl), 0);
    chk("R2 glb pulse", srst_pulses, 1);

    // R9 freeze asked during pending reset
    wr(8'h01);
    wr(8'h03);
    idle(2);
    chk("R9 freeze held back", int'(presc), 1);
    idle(20);
    chk("R9 freeze cleared by reset", int'(ctrl), 0);
    chk("R9 never frozen", int'(frz_ack), 0);

    // R9 disable asked during pending reset, taken after completion
    wr(8'h01);
    wr(8'h05);
    idle(2);
    chk("R9 disable held back", int'(presc), 1);
    idle(25);
    chk("R9 disable kept", int'(ctrl), 'h04);
    chk("R9 disable granted after", int'(lpm_ack), 1);
    wr(8'h00);
    idle(8);

    // mixed traffic against the model
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      tx = lfsr[0]; rx = lfsr[1] & lfsr[2];
      if (lfsr[7:4] == 4'h3) wr({5'b0, lfsr[10:9], 1'b0});
      else if (lfsr[11:5] == 7'h11) wr(8'h01);
      else @(negedge clk);
    end
    tx = 1'b0; rx = 1'b0;
    idle(20);
    finish_run();
  end
endmodule